// File: doc/BRIEF.md
# Dual-Channel Loopback Serial Register File

This block is the host-facing register file of a two-channel serial controller that runs in internal loopback. It sits on an 8-bit processor I/O bus with separate read and write strobes and occupies four consecutive port addresses. Each channel has a data port and a control port. A byte written to a channel's data port is held in a one-byte buffer, and the next read of that data port returns it. This lets software exercise its serial driver without a line attached.

Control registers are reached indirectly. A write to a channel's control port while its pointer is zero loads a new pointer. The next control access then reaches the register that pointer selects, and the pointer returns to zero afterwards. Reading register 0 returns a status byte built from buffer occupancy and two modem-control bits. Register 1 returns an error byte that carries a sticky overrun flag. Channel B also holds the shared interrupt vector. Bit timing, interrupt requests and external modem lines are not modelled.

Top module: `sio_loop_top`

## Requirements
- R1: After reset, io_rdata_o is 0x00, both pointers are 0, both buffers are empty, both overrun flags are clear and the vector is 0x00. A status read then returns 0x04 and a register-1 read returns 0x00.
- R2: Ports sit at BASE_ADDR (0xFC) to BASE_ADDR+3. Address bit 1 selects the channel (0 = A, 1 = B) and address bit 0 selects data (0) or control (1): 0xFC is A data, 0xFD is A control, 0xFE is B data and 0xFF is B control. The channels keep fully separate state. Writes outside the window change nothing, and reads outside it return 0x00.
- R3: A control write while the pointer is 0 loads the pointer from wdata bits 2:0. A control write with a nonzero pointer, and every control read, leave the pointer at 0.
- R4: A control write with pointer n is delivered to register n. Register 5 keeps bits 1 and 7 for the status byte. Writes to registers 3, 4, 6 and 7 change no readable state.
- R5: A control read with pointer 0 returns a status byte. Bit 5 is register-5 bit 1. Bit 3 is register-5 bit 7. Bit 0 is 1 when a byte is pending and bit 2 is 1 when none is. All other bits are 0.
- R6: A data write stores the byte, replacing any older one, and marks it pending. A data write while a byte is already pending sets overrun (register-1 bit 5), which stays set until reset.
- R7: A data read with a byte pending returns it and clears the pending flag. A data read with nothing pending returns 0x00.
- R8: A control write to register 2 on channel B loads the vector, and a control read of register 2 on channel B returns it. On channel A, writing register 2 leaves the vector unchanged and reading it returns 0x00.
- R9: A control read of register 1 returns the channel's register-1 byte. Reads of registers 3 to 7 return 0x00.
- R10: Read data is registered. It appears on io_rdata_o after the clock edge that samples io_rd_i and holds until the next accepted read. When io_rd_i and io_wr_i are both high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 8 | I/O port address |
| io_wr_i | input | 1 | Write strobe, one access per cycle high |
| io_rd_i | input | 1 | Read strobe, one access per cycle high |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Registered read data |

## Verification
The bench targets the pointer's return to zero after a register-1 read. A design that kept the pointer would answer a second control read with the error byte instead of the status byte. Two writes to one data port without a read in between must set overrun and keep the newer byte. A design that dropped the new byte, or cleared overrun on a read, fails the read-backs that follow. Register 2 is written on channel A and then the vector is read on channel B; a design that ignored the channel would corrupt the vector. Reads of empty buffers, unimplemented registers and out-of-window ports must return zero, and pending data must be drained exactly once.

// File: rtl/sio_loop_pkg.sv
package sio_loop_pkg;

  localparam int NUM_CH = 2;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 3;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [PTR_W-1:0]  ptr_t;

  // register numbers reached through the pointer
  localparam ptr_t REG_CMD   = 3'd0;
  localparam ptr_t REG_ERR   = 3'd1;
  localparam ptr_t REG_VEC   = 3'd2;
  localparam ptr_t REG_MODEM = 3'd5;

  // status byte layout
  localparam int ST_PEND_BIT  = 0;
  localparam int ST_EMPTY_BIT = 2;
  localparam int ST_DTR_BIT   = 3;
  localparam int ST_RTS_BIT   = 5;

  // modem register bits consumed
  localparam int MDM_RTS_BIT = 1;
  localparam int MDM_DTR_BIT = 7;

  // error byte layout
  localparam int ERR_OVR_BIT = 5;

  typedef struct packed {
    logic dat_wr;
    logic dat_rd;
    logic ctl_wr;
    logic ctl_rd;
  } chan_strb_t;

endpackage

// File: rtl/sio_loop_dec.sv
module sio_loop_dec
  import sio_loop_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          NCH       = NUM_CH,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hFC
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output chan_strb_t        strb_o [NCH]
);

  localparam int CTL_BIT = 0;
  localparam int CH_BIT  = 1;

  logic hit;
  logic rd_eff;

  assign hit    = (addr_i[ADDR_W-1:CH_BIT+1] == BASE_ADDR[ADDR_W-1:CH_BIT+1]);
  assign rd_eff = rd_i & ~wr_i;  // write wins on collision

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = hit && (addr_i[CH_BIT] == c[0]);
    assign strb_o[c].dat_wr = sel && !addr_i[CTL_BIT] && wr_i;
    assign strb_o[c].dat_rd = sel && !addr_i[CTL_BIT] && rd_eff;
    assign strb_o[c].ctl_wr = sel &&  addr_i[CTL_BIT] && wr_i;
    assign strb_o[c].ctl_rd = sel &&  addr_i[CTL_BIT] && rd_eff;
  end

endmodule

// File: rtl/sio_loop_chan.sv
module sio_loop_chan
  import sio_loop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  chan_strb_t strb_i,
  input  byte_t      wdata_i,
  output byte_t      rdata_o,
  output ptr_t       ptr_o
);

  ptr_t  ptr_q;
  logic  rts_q, dtr_q;
  byte_t buf_q;
  logic  pend_q;
  logic  ovr_q;

  // pointer and modem bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      rts_q <= 1'b0;
      dtr_q <= 1'b0;
    end else if (strb_i.ctl_wr) begin
      if (ptr_q == REG_CMD) ptr_q <= wdata_i[PTR_W-1:0];
      else                  ptr_q <= '0;
      if (ptr_q == REG_MODEM) begin
        rts_q <= wdata_i[MDM_RTS_BIT];
        dtr_q <= wdata_i[MDM_DTR_BIT];
      end
    end else if (strb_i.ctl_rd) begin
      ptr_q <= '0;
    end
  end

  // one-byte loopback buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (strb_i.dat_wr) begin
      buf_q  <= wdata_i;
      pend_q <= 1'b1;
      if (pend_q) ovr_q <= 1'b1;
    end else if (strb_i.dat_rd) begin
      pend_q <= 1'b0;
    end
  end

  byte_t st_byte, err_byte, ctl_val, dat_val;

  always_comb begin
    st_byte               = '0;
    st_byte[ST_RTS_BIT]   = rts_q;
    st_byte[ST_DTR_BIT]   = dtr_q;
    st_byte[ST_EMPTY_BIT] = ~pend_q;
    st_byte[ST_PEND_BIT]  = pend_q;
    err_byte              = '0;
    err_byte[ERR_OVR_BIT] = ovr_q;
  end

  always_comb begin
    unique case (ptr_q)
      REG_CMD: ctl_val = st_byte;
      REG_ERR: ctl_val = err_byte;
      default: ctl_val = '0;
    endcase
  end

  assign dat_val = pend_q ? buf_q : '0;

  always_comb begin
    rdata_o = '0;
    if (strb_i.ctl_rd)      rdata_o = ctl_val;
    else if (strb_i.dat_rd) rdata_o = dat_val;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/sio_loop_top.sv
module sio_loop_top
  import sio_loop_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hFC,
  parameter int                VEC_CH    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o
);

  chan_strb_t strb [NUM_CH];
  byte_t      chan_rdata [NUM_CH];
  ptr_t       chan_ptr [NUM_CH];
  byte_t      vec_q;
  byte_t      rd_mux;
  byte_t      rdata_q;
  logic       rd_en;

  sio_loop_dec #(
    .ADDR_W   (ADDR_W),
    .NCH      (NUM_CH),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr_i(io_addr_i),
    .wr_i  (io_wr_i),
    .rd_i  (io_rd_i),
    .strb_o(strb)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    sio_loop_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .strb_i (strb[c]),
      .wdata_i(io_wdata_i),
      .rdata_o(chan_rdata[c]),
      .ptr_o  (chan_ptr[c])
    );
  end

  logic vec_wr, vec_rd;
  assign vec_wr = strb[VEC_CH].ctl_wr && (chan_ptr[VEC_CH] == REG_VEC);
  assign vec_rd = strb[VEC_CH].ctl_rd && (chan_ptr[VEC_CH] == REG_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_q <= '0;
    else if (vec_wr) vec_q <= io_wdata_i;
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) rd_mux |= chan_rdata[c];
    if (vec_rd) rd_mux = vec_q;
  end

  assign rd_en = io_rd_i && !io_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign io_rdata_o = rdata_q;

endmodule

// File: rtl/sio_loop_chk.sv
module sio_loop_chk
  import sio_loop_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hFC,
  parameter int                VEC_CH    = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [DATA_W-1:0] io_wdata_i,
  input logic [DATA_W-1:0] io_rdata_o,
  input ptr_t              chan_ptr [NUM_CH],
  input byte_t             vec_q
);

  logic rd_only, in_win;
  assign rd_only = io_rd_i && !io_wr_i;
  assign in_win  = (io_addr_i[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);

  // R2: reads outside the window return zero
  p_outside_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_only && !in_win |=> io_rdata_o == '0);

  // R10: read data holds when no read is accepted
  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_only |=> $stable(io_rdata_o));

  // R8: vector loads from a channel-B register-2 write
  p_vec_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_i && io_addr_i == (BASE_ADDR | ADDR_W'({VEC_CH[0], 1'b1}))
      && chan_ptr[VEC_CH] == REG_VEC
    |=> vec_q == $past(io_wdata_i));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic [ADDR_W-1:0] dat_a, ctl_a;
    assign dat_a = BASE_ADDR | ADDR_W'({c[0], 1'b0});
    assign ctl_a = BASE_ADDR | ADDR_W'({c[0], 1'b1});

    // R3: pointer is zero after any control read
    p_ptr_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_only && io_addr_i == ctl_a |=> chan_ptr[c] == '0);

    // R5: status byte flags exactly one of pending/empty
    p_status_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_only && io_addr_i == ctl_a && chan_ptr[c] == REG_CMD
      |=> io_rdata_o[ST_PEND_BIT] != io_rdata_o[ST_EMPTY_BIT]);

    // R9: unimplemented registers read zero
    p_unimpl_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_only && io_addr_i == ctl_a && chan_ptr[c] > REG_VEC
      |=> io_rdata_o == '0);

    // R7: second back-to-back data read finds the buffer drained
    p_drained_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_only && io_addr_i == dat_a) ##1 (rd_only && io_addr_i == dat_a)
      |=> io_rdata_o == '0);
  end

endmodule

bind sio_loop_top sio_loop_chk #(
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR),
  .VEC_CH   (VEC_CH)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .io_addr_i (io_addr_i),
  .io_wr_i   (io_wr_i),
  .io_rd_i   (io_rd_i),
  .io_wdata_i(io_wdata_i),
  .io_rdata_o(io_rdata_o),
  .chan_ptr  (chan_ptr),
  .vec_q     (vec_q)
);

// File: tb/tb_sio_loop_top.sv
`timescale 1ns/1ps
module tb_sio_loop_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       mon_pend = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sio_loop_top dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .io_addr_i (addr),
    .io_wr_i   (wr),
    .io_rd_i   (rd),
    .io_wdata_i(wdata),
    .io_rdata_o(rdata)
  );

  // monitor: a read accepted at a posedge is compared at the next negedge
  always @(posedge clk) mon_pend <= rd && !wr;

  always @(negedge clk) begin
    if (mon_pend) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  task automatic wr_port(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_port(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic direct(input logic [7:0] e, input string t);
    checks++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s: rdata=%02h expected=%02h", t, rdata, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    direct(8'h00, "R1 rdata after reset");

    // R1 reset state
    rd_port(8'hFD, 8'h04, "R1 A status");
    rd_port(8'hFF, 8'h04, "R1 B status");
    rd_port(8'hFC, 8'h00, "R1 A buffer empty");
    wr_port(8'hFD, 8'h01);
    rd_port(8'hFD, 8'h00, "R1 A reg1");
    wr_port(8'hFF, 8'h02);
    rd_port(8'hFF, 8'h00, "R1 vector");

    // R6/R7 data path on A
    wr_port(8'hFC, 8'h5A);
    rd_port(8'hFD, 8'h01, "R5 pending status");
    rd_port(8'hFC, 8'h5A, "R7 data read");
    rd_port(8'hFC, 8'h00, "R7 drained");
    rd_port(8'hFD, 8'h04, "R7 empty status");

    // R6 overrun on B
    wr_port(8'hFE, 8'h11);
    wr_port(8'hFE, 8'h22);
    wr_port(8'hFF, 8'h01);
    rd_port(8'hFF, 8'h20, "R6 overrun set");
    rd_port(8'hFE, 8'h22, "R6 newest byte kept");
    rd_port(8'hFE, 8'h00, "R7 B drained");
    wr_port(8'hFD, 8'h01);
    rd_port(8'hFD, 8'h00, "R2 A unaffected by B");
    wr_port(8'hFF, 8'h01);
    rd_port(8'hFF, 8'h20, "R6 overrun sticky");

    // R3 pointer cleared after read
    rd_port(8'hFF, 8'h04, "R3 pointer back to 0");

    // R8 vector
    wr_port(8'hFF, 8'h02);
    wr_port(8'hFF, 8'hA7);
    wr_port(8'hFF, 8'h02);
    rd_port(8'hFF, 8'hA7, "R8 vector read");
    rd_port(8'hFF, 8'h04, "R3 status after vector");
    wr_port(8'hFD, 8'h02);
    wr_port(8'hFD, 8'h33);
    wr_port(8'hFF, 8'h02);
    rd_port(8'hFF, 8'hA7, "R8 A reg2 no vector effect");
    wr_port(8'hFD, 8'h02);
    rd_port(8'hFD, 8'h00, "R8 A reg2 reads 0");

    // R9 unimplemented
    wr_port(8'hFD, 8'h03);
    wr_port(8'hFD, 8'h55);
    wr_port(8'hFD, 8'h03);
    rd_port(8'hFD, 8'h00, "R9 reg3 reads 0");
    wr_port(8'hFF, 8'h07);
    rd_port(8'hFF, 8'h00, "R9 reg7 reads 0");

    // R2 outside window
    wr_port(8'h7C, 8'h99);
    wr_port(8'hF0, 8'h98);
    rd_port(8'hFC, 8'h00, "R2 outside write ignored");
    rd_port(8'h7D, 8'h00, "R2 outside read 0");
    rd_port(8'hFB, 8'h00, "R2 below window read 0");

    // R2 interleaved channels
    wr_port(8'hFC, 8'h3C);
    wr_port(8'hFE, 8'h4D);
    rd_port(8'hFE, 8'h4D, "R2 B data");
    rd_port(8'hFC, 8'h3C, "R2 A data");

    // R4/R5 modem bits
    wr_port(8'hFD, 8'h05);
    wr_port(8'hFD, 8'h82);
    rd_port(8'hFD, 8'h2C, "R5 rts+dtr");
    wr_port(8'hFD, 8'h05);
    wr_port(8'hFD, 8'h80);
    rd_port(8'hFD, 8'h0C, "R5 dtr only");
    wr_port(8'hFD, 8'h05);
    wr_port(8'hFD, 8'h02);
    rd_port(8'hFD, 8'h24, "R5 rts only");
    wr_port(8'hFD, 8'h04);
    wr_port(8'hFD, 8'hFF);
    rd_port(8'hFD, 8'h24, "R4 reg4 no status effect");
    rd_port(8'hFF, 8'h04, "R4 B modem untouched");

    // R10 hold and collision
    wr_port(8'hFC, 8'h77);
    rd_port(8'hFC, 8'h77, "R10 read value");
    repeat (3) @(negedge clk);
    direct(8'h77, "R10 hold");
    wr_port(8'hFC, 8'h66);
    @(negedge clk);
    addr = 8'hFC; wdata = 8'h44; wr = 1'b1; rd = 1'b1;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    direct(8'h77, "R10 collision read ignored");
    wr_port(8'hFD, 8'h01);
    rd_port(8'hFD, 8'h20, "R10 collision write performed");
    rd_port(8'hFC, 8'h44, "R10 collision data");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule